// File: doc/BRIEF.md
# Swap Victim Buffer

This block is a small fully associative buffer of recently evicted blocks that sits beside a set-associative primary cache. It keeps only the bookkeeping for each entry: a block-aligned address used as the tag, a valid bit, a dirty bit and an LRU age. The data payload is held elsewhere. The primary cache consults it only when a request misses and the target set has no free way. In that case it issues one swap request that names the missed block X, the evicted primary block V and V's dirty bit.

On a swap hit the two blocks trade places. V, with its own dirty bit, takes the entry that held X, and the stored dirty bit of X is returned to the primary cache. The primary cache then sets that bit again if the triggering access was a write. On a swap miss the buffer makes room for V. It uses the lowest-numbered invalid entry if there is one. Otherwise it evicts its least recently used entry as a secondary victim. A dirty secondary victim is offered on a writeback port and must be accepted before V is inserted and the done strobe fires. The primary cache issues its fill read for X only after done. Any entry that is filled or swapped becomes the most recent.

Counters report accepted swap requests, successful swaps and the combined miss count. The combined miss count is the number of primary misses signalled on `miss_evt` minus the number of swaps. Setting the entry count to zero removes the buffer.

Top module: `victim_swap_cache`

## Requirements
- R1: After reset every entry is invalid, `busy`, `done`, `swap_hit` and `wb_valid` are 0, and all three counters are 0.
- R2: A swap request accepted while `busy` is 0 whose X address matches a valid entry gives `done`=1 and `swap_hit`=1 in the next cycle, with `x_dirty` equal to the dirty bit stored with X.
- R3: After a swap hit, the entry that held X holds V with V's dirty bit, and X is no longer present. A later request for V hits and returns that bit, and a later request for X misses.
- R4: A miss while some entry is invalid fills the lowest-numbered invalid entry with V. It gives `done`=1 and `swap_hit`=0 in the next cycle, with no writeback.
- R5: A miss while all entries are valid replaces the entry whose last fill or swap is the oldest. A clean secondary victim causes no writeback, and `done` follows in the next cycle.
- R6: A dirty secondary victim raises `wb_valid` with its block address on `wb_addr`, one cycle after the request. Both are held until a cycle with `wb_ready`=1. `done` (with `swap_hit`=0) is asserted only in the cycle after that handshake, and V is inserted at that point.
- R7: `swap_req` has no effect while `busy` is 1. The buffer contents, the LRU order and the counters are left unchanged.
- R8: `req_count` increments once per accepted swap request. `swap_count` increments once per swap hit, in the same cycle that the hit's `done` appears.
- R9: `combined_miss` equals the number of cycles with `miss_evt`=1 minus `swap_count`.
- R10: With ENTRIES=0, every request is answered with `done`=1 and `swap_hit`=0 in the next cycle. There is never a writeback, and `req_count` and `swap_count` stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| swap_req | input | 1 | Swap request strobe from the primary cache |
| x_addr | input | ADDR_W | Block address of the missed block X |
| v_addr | input | ADDR_W | Block address of the primary victim V |
| v_dirty | input | 1 | Dirty bit of V |
| miss_evt | input | 1 | One pulse per primary read or write miss |
| wb_ready | input | 1 | Downstream accepts the writeback |
| busy | output | 1 | Waiting for a writeback handshake; requests are ignored |
| done | output | 1 | Request complete; the primary fill of X may proceed |
| swap_hit | output | 1 | X was found and exchanged (valid with done) |
| x_dirty | output | 1 | Stored dirty bit of X (valid with done and swap_hit) |
| wb_valid | output | 1 | Writeback of a dirty secondary victim pending |
| wb_addr | output | ADDR_W | Block address of the secondary victim |
| req_count | output | CNT_W | Accepted swap requests |
| swap_count | output | CNT_W | Successful swaps |
| combined_miss | output | CNT_W | Primary misses minus swaps |

## Verification
The bench builds the block twice: once with four entries and a 26-bit block address, and once with zero entries. Four entries is small enough that a few requests fill the buffer. This brings LRU eviction, dirty and clean secondary victims, and requests ignored during a writeback stall within reach. A pseudo-random stream of requests over twelve addresses then keeps hits, misses and evictions interleaved. The zero-entry build exercises the variant in which the buffer is absent.

// File: rtl/vcs_pkg.sv
package vcs_pkg;

  typedef enum logic [0:0] {
    VS_IDLE  = 1'b0,
    VS_DRAIN = 1'b1
  } vs_state_e;

  // index width that stays legal for one entry
  function automatic int unsigned idx_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // primary misses not rescued by a swap
  function automatic logic [31:0] net_misses(logic [31:0] misses, logic [31:0] swaps);
    return misses - swaps;
  endfunction

  // age of a touched entry's peer after the touch
  function automatic logic [31:0] aged(logic [31:0] own, logic [31:0] touched, logic is_self);
    if (is_self) return 32'd0;
    if (own < touched) return own + 32'd1;
    return own;
  endfunction

endpackage

// File: rtl/vcs_match.sv
module vcs_match #(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned ADDR_W  = 26,
  parameter int unsigned IDX_W   = 2,
  parameter int unsigned AGE_W   = 2
) (
  input  logic [ENTRIES-1:0]             valid,
  input  logic [ENTRIES-1:0][ADDR_W-1:0] tags,
  input  logic [ENTRIES-1:0][AGE_W-1:0]  ages,
  input  logic [ADDR_W-1:0]              probe,
  output logic                           hit,
  output logic [IDX_W-1:0]               hit_idx,
  output logic                           any_free,
  output logic [IDX_W-1:0]               free_idx,
  output logic [IDX_W-1:0]               lru_idx
);
  localparam logic [AGE_W-1:0] OLDEST = AGE_W'(ENTRIES - 1);

  always_comb begin
    hit      = 1'b0;
    hit_idx  = '0;
    any_free = 1'b0;
    free_idx = '0;
    lru_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (valid[i] && tags[i] == probe) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
      if (!valid[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
      if (ages[i] == OLDEST) lru_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/vcs_age.sv
module vcs_age #(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned IDX_W   = 2,
  parameter int unsigned AGE_W   = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          touch,
  input  logic [IDX_W-1:0]              touch_idx,
  output logic [ENTRIES-1:0][AGE_W-1:0] ages
);
  import vcs_pkg::*;

  logic [AGE_W-1:0] touched_age;
  assign touched_age = ages[touch_idx];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_age
    logic [31:0] next_age;
    assign next_age = aged(32'(ages[g]), 32'(touched_age), touch_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)     ages[g] <= AGE_W'(g);
      else if (touch) ages[g] <= next_age[AGE_W-1:0];
    end
  end
endmodule

// File: rtl/vcs_counters.sv
module vcs_counters #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_inc,
  input  logic             hit_inc,
  input  logic             miss_inc,
  output logic [CNT_W-1:0] req_cnt,
  output logic [CNT_W-1:0] hit_cnt,
  output logic [CNT_W-1:0] combined
);
  import vcs_pkg::*;

  logic [CNT_W-1:0] miss_cnt;
  logic [31:0]      net;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_cnt  <= '0;
      hit_cnt  <= '0;
      miss_cnt <= '0;
    end else begin
      if (req_inc)  req_cnt  <= req_cnt + 1'b1;
      if (hit_inc)  hit_cnt  <= hit_cnt + 1'b1;
      if (miss_inc) miss_cnt <= miss_cnt + 1'b1;
    end
  end

  assign net      = net_misses(32'(miss_cnt), 32'(hit_cnt));
  assign combined = net[CNT_W-1:0];
endmodule

// File: rtl/victim_swap_cache.sv
module victim_swap_cache #(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned ADDR_W  = 26,
  parameter int unsigned CNT_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              swap_req,
  input  logic [ADDR_W-1:0] x_addr,
  input  logic [ADDR_W-1:0] v_addr,
  input  logic              v_dirty,
  input  logic              miss_evt,
  input  logic              wb_ready,
  output logic              busy,
  output logic              done,
  output logic              swap_hit,
  output logic              x_dirty,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [CNT_W-1:0]  req_count,
  output logic [CNT_W-1:0]  swap_count,
  output logic [CNT_W-1:0]  combined_miss
);
  import vcs_pkg::*;

  localparam int unsigned IDX_W = idx_width(ENTRIES);
  localparam int unsigned AGE_W = idx_width(ENTRIES);

  // named internal events
  logic ev_accept;
  logic ev_hit;

  if (ENTRIES == 0) begin : g_absent
    logic done_q;
    always_ff @(posedge clk) begin
      if (!rst_n) done_q <= 1'b0;
      else        done_q <= swap_req;
    end
    assign ev_accept = 1'b0;
    assign ev_hit    = 1'b0;
    assign busy      = 1'b0;
    assign done      = done_q;
    assign swap_hit  = 1'b0;
    assign x_dirty   = 1'b0;
    assign wb_valid  = 1'b0;
    assign wb_addr   = '0;
  end else begin : g_present
    vs_state_e                     state_q;
    logic [ENTRIES-1:0]            valid_q;
    logic [ENTRIES-1:0]            dirty_q;
    logic [ENTRIES-1:0][ADDR_W-1:0] tag_q;
    logic [ENTRIES-1:0][AGE_W-1:0] age_w;

    logic              lk_hit, lk_free;
    logic [IDX_W-1:0]  lk_idx, free_idx, lru_idx;
    logic              ev_evict_wb, ev_commit;
    logic [IDX_W-1:0]  ins_idx, wr_idx;
    logic [ADDR_W-1:0] wr_addr;
    logic              wr_dirty;

    logic [ADDR_W-1:0] pend_addr_q;
    logic              pend_dirty_q;
    logic [IDX_W-1:0]  pend_idx_q;
    logic              wb_valid_q;
    logic [ADDR_W-1:0] wb_addr_q;
    logic              done_q, hit_q, xd_q;

    vcs_match #(
      .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .AGE_W(AGE_W)
    ) u_match (
      .valid   (valid_q),
      .tags    (tag_q),
      .ages    (age_w),
      .probe   (x_addr),
      .hit     (lk_hit),
      .hit_idx (lk_idx),
      .any_free(lk_free),
      .free_idx(free_idx),
      .lru_idx (lru_idx)
    );

    assign ev_accept   = swap_req && (state_q == VS_IDLE);
    assign ev_hit      = ev_accept && lk_hit;
    assign ev_evict_wb = ev_accept && !lk_hit && !lk_free && dirty_q[lru_idx];
    assign ev_commit   = (ev_accept && !ev_evict_wb) ||
                         (state_q == VS_DRAIN && wb_ready);
    assign ins_idx     = lk_free ? free_idx : lru_idx;
    assign wr_idx      = (state_q == VS_DRAIN) ? pend_idx_q :
                         (lk_hit ? lk_idx : ins_idx);
    assign wr_addr     = (state_q == VS_DRAIN) ? pend_addr_q : v_addr;
    assign wr_dirty    = (state_q == VS_DRAIN) ? pend_dirty_q : v_dirty;

    vcs_age #(
      .ENTRIES(ENTRIES), .IDX_W(IDX_W), .AGE_W(AGE_W)
    ) u_age (
      .clk      (clk),
      .rst_n    (rst_n),
      .touch    (ev_commit),
      .touch_idx(wr_idx),
      .ages     (age_w)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          valid_q[g] <= 1'b0;
          dirty_q[g] <= 1'b0;
          tag_q[g]   <= '0;
        end else if (ev_commit && wr_idx == IDX_W'(g)) begin
          valid_q[g] <= 1'b1;
          dirty_q[g] <= wr_dirty;
          tag_q[g]   <= wr_addr;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        state_q      <= VS_IDLE;
        pend_addr_q  <= '0;
        pend_dirty_q <= 1'b0;
        pend_idx_q   <= '0;
        wb_valid_q   <= 1'b0;
        wb_addr_q    <= '0;
        done_q       <= 1'b0;
        hit_q        <= 1'b0;
        xd_q         <= 1'b0;
      end else begin
        done_q <= ev_commit;
        hit_q  <= ev_hit;
        xd_q   <= ev_hit ? dirty_q[lk_idx] : 1'b0;
        case (state_q)
          VS_IDLE: begin
            if (ev_evict_wb) begin
              state_q      <= VS_DRAIN;
              wb_valid_q   <= 1'b1;
              wb_addr_q    <= tag_q[lru_idx];
              pend_addr_q  <= v_addr;
              pend_dirty_q <= v_dirty;
              pend_idx_q   <= lru_idx;
            end
          end
          default: begin
            if (wb_ready) begin
              state_q    <= VS_IDLE;
              wb_valid_q <= 1'b0;
            end
          end
        endcase
      end
    end

    assign busy     = (state_q == VS_DRAIN);
    assign done     = done_q;
    assign swap_hit = hit_q;
    assign x_dirty  = xd_q;
    assign wb_valid = wb_valid_q;
    assign wb_addr  = wb_addr_q;
  end

  vcs_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_inc (ev_accept),
    .hit_inc (ev_hit),
    .miss_inc(miss_evt),
    .req_cnt (req_count),
    .hit_cnt (swap_count),
    .combined(combined_miss)
  );
endmodule

// File: rtl/vcs_chk.sv
module vcs_chk #(
  parameter int unsigned ADDR_W = 26,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              swap_req,
  input logic              busy,
  input logic              done,
  input logic              swap_hit,
  input logic              wb_valid,
  input logic              wb_ready,
  input logic [ADDR_W-1:0] wb_addr,
  input logic [CNT_W-1:0]  req_count,
  input logic [CNT_W-1:0]  swap_count
);
  // R2
  req_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_req && !busy |=> done || wb_valid);

  // R2
  hit_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_hit |-> done);

  // R6
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr));

  // R6
  wb_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wb_valid) |-> done && !swap_hit);

  // R6
  wb_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> busy);

  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(req_count));

  // R8
  hit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && swap_hit |-> swap_count == $past(swap_count) + 1'b1);
endmodule

bind victim_swap_cache vcs_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .swap_req  (swap_req),
  .busy      (busy),
  .done      (done),
  .swap_hit  (swap_hit),
  .wb_valid  (wb_valid),
  .wb_ready  (wb_ready),
  .wb_addr   (wb_addr),
  .req_count (req_count),
  .swap_count(swap_count)
);

// File: tb/victim_swap_cache_bench.sv
module victim_swap_cache_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int AW = 26;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic          swap_req = 1'b0, v_dirty = 1'b0, miss_evt = 1'b0, wb_ready = 1'b0;
  logic [AW-1:0] x_addr = '0, v_addr = '0;
  logic          busy, done, swap_hit, x_dirty, wb_valid;
  logic [AW-1:0] wb_addr;
  logic [CW-1:0] req_count, swap_count, combined_miss;

  victim_swap_cache #(.ENTRIES(N), .ADDR_W(AW), .CNT_W(CW)) u_victim_swap_cache (
    .clk(clk), .rst_n(rst_n), .swap_req(swap_req), .x_addr(x_addr), .v_addr(v_addr),
    .v_dirty(v_dirty), .miss_evt(miss_evt), .wb_ready(wb_ready), .busy(busy),
    .done(done), .swap_hit(swap_hit), .x_dirty(x_dirty), .wb_valid(wb_valid),
    .wb_addr(wb_addr), .req_count(req_count), .swap_count(swap_count),
    .combined_miss(combined_miss));

  logic          z_req = 1'b0, z_miss = 1'b0;
  logic          z_busy, z_done, z_hit, z_xd, z_wbv;
  logic [AW-1:0] z_wba;
  logic [CW-1:0] z_reqc, z_swc, z_comb;

  victim_swap_cache #(.ENTRIES(0), .ADDR_W(AW), .CNT_W(CW)) u_victim_swap_cache_off (
    .clk(clk), .rst_n(rst_n), .swap_req(z_req), .x_addr(x_addr), .v_addr(v_addr),
    .v_dirty(v_dirty), .miss_evt(z_miss), .wb_ready(1'b0), .busy(z_busy),
    .done(z_done), .swap_hit(z_hit), .x_dirty(z_xd), .wb_valid(z_wbv),
    .wb_addr(z_wba), .req_count(z_reqc), .swap_count(z_swc), .combined_miss(z_comb));

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model: MRU at index 0
  logic [AW-1:0] m_addr[$];
  bit            m_dirty[$];
  logic [1:0]    exp_q[$];   // {hit, x_dirty}
  logic [AW-1:0] wb_q[$];
  int exp_reqs = 0, exp_hits = 0, miss_pulses = 0;

  function automatic bit in_model(logic [AW-1:0] a);
    foreach (m_addr[i]) if (m_addr[i] == a) return 1'b1;
    return 1'b0;
  endfunction

  task automatic model_req(input logic [AW-1:0] x, input logic [AW-1:0] v, input bit vd);
    int found = -1;
    bit xd = 1'b0;
    foreach (m_addr[i]) if (m_addr[i] == x) found = i;
    exp_reqs++;
    if (found >= 0) begin
      xd = m_dirty[found];
      m_addr.delete(found);
      m_dirty.delete(found);
      exp_hits++;
    end else if (m_addr.size() == N) begin
      if (m_dirty[N-1]) wb_q.push_back(m_addr[N-1]);
      void'(m_addr.pop_back());
      void'(m_dirty.pop_back());
    end
    m_addr.push_front(v);
    m_dirty.push_front(vd);
    exp_q.push_back({found >= 0, xd});
  endtask

  // monitor: compare completions against the scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        chk("R2 unexpected done", 32'd1, 32'd0);
      end else begin
        logic [1:0] e;
        e = exp_q.pop_front();
        chk("R2/R4/R5 swap_hit", 32'(swap_hit), 32'(e[1]));
        if (e[1]) chk("R2/R3 x_dirty", 32'(x_dirty), 32'(e[0]));
      end
    end
  end

  // downstream writeback responder
  int wb_wait = 0;
  always @(negedge clk) begin
    if (wb_ready) begin
      wb_ready <= 1'b0;
      wb_wait  <= 0;
    end else if (rst_n && wb_valid) begin
      if (wb_wait == 2) begin
        if (wb_q.size() == 0) chk("R5 unexpected writeback", 32'd1, 32'd0);
        else chk("R6 wb_addr", 32'(wb_addr), 32'(wb_q.pop_front()));
        chk("R6 done held off during writeback", 32'(done), 32'd0);
        wb_ready <= 1'b1;
      end else begin
        wb_wait <= wb_wait + 1;
      end
    end
  end

  task automatic wait_idle();
    for (int k = 0; k < 50; k++) begin
      if (exp_q.size() == 0) break;
      @(negedge clk); #1;
    end
  endtask

  task automatic issue(input logic [AW-1:0] x, input logic [AW-1:0] v, input bit vd,
                       input bit poke_busy);
    model_req(x, v, vd);
    x_addr = x; v_addr = v; v_dirty = vd; swap_req = 1'b1;
    @(negedge clk); #1;
    swap_req = 1'b0;
    if (poke_busy) begin
      chk("R7 busy during writeback", 32'(busy), 32'd1);
      x_addr = 26'h22; v_addr = 26'h777; v_dirty = 1'b1; swap_req = 1'b1;
      @(negedge clk); #1;
      swap_req = 1'b0;
    end
    wait_idle();
    chk("R6 writeback drained", 32'(wb_q.size()), 32'd0);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 swap_hit", 32'(swap_hit), 0);
    chk("R1 wb_valid", 32'(wb_valid), 0);
    chk("R1 counters", 32'(req_count) | 32'(swap_count) | 32'(combined_miss), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R4 fill free entries
    issue(26'h100, 26'h10, 1'b0, 1'b0);
    issue(26'h101, 26'h11, 1'b1, 1'b0);
    issue(26'h102, 26'h12, 1'b0, 1'b0);
    issue(26'h103, 26'h13, 1'b1, 1'b0);
    // R2 hit with dirty X
    issue(26'h11, 26'h20, 1'b0, 1'b0);
    // R3 X gone; R5 clean LRU victim 0x10
    issue(26'h11, 26'h21, 1'b0, 1'b0);
    // R3 V carried its dirty bit (0)
    issue(26'h20, 26'h22, 1'b1, 1'b0);
    issue(26'h500, 26'h23, 1'b0, 1'b0);
    // R6 dirty secondary victim 0x13, R7 poke while busy
    issue(26'h501, 26'h24, 1'b1, 1'b1);
    // R7 ignored V 0x777 must not be present
    issue(26'h777, 26'h25, 1'b0, 1'b0);
    // R3 hit on 0x22 stored dirty
    issue(26'h22, 26'h26, 1'b0, 1'b0);
    // mixed stream
    begin
      logic [31:0] r = 32'h1234_5678;
      for (int n = 0; n < 40; n++) begin
        logic [AW-1:0] xa, va;
        r = r * 32'd1103515245 + 32'd12345;
        xa = AW'(32'h300 + (r[19:16] % 12));
        va = AW'(32'h300 + (r[27:24] % 12));
        while (va == xa || in_model(va)) va = AW'(32'h300 + ((va - 26'h300 + 1) % 12));
        issue(xa, va, r[8], 1'b0);
      end
    end
    // R9 primary misses
    for (int k = 0; k < 60; k++) begin
      miss_evt = 1'b1; @(negedge clk); #1; miss_pulses++;
    end
    miss_evt = 1'b0;
    @(negedge clk); #1;
    chk("R8 req_count", 32'(req_count), 32'(exp_reqs));
    chk("R8 swap_count", 32'(swap_count), 32'(exp_hits));
    chk("R9 combined_miss", 32'(combined_miss), 32'(miss_pulses - exp_hits));
    chk("R2 no pending expectations", 32'(exp_q.size()), 0);
    // R10 absent buffer
    z_req = 1'b1; @(negedge clk); #1; z_req = 1'b0;
    chk("R10 done", 32'(z_done), 1);
    chk("R10 swap_hit", 32'(z_hit), 0);
    chk("R10 wb_valid", 32'(z_wbv), 0);
    for (int k = 0; k < 3; k++) begin
      z_miss = 1'b1; @(negedge clk); #1;
    end
    z_miss = 1'b0;
    @(negedge clk); #1;
    chk("R10 counters zero", 32'(z_reqc) | 32'(z_swc), 0);
    chk("R10 combined", 32'(z_comb), 3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule